// File: doc/BRIEF.md
# Serial-Memory Interrupt Status and Mask Unit

This unit collects the event pulses produced by a serial-memory transfer engine and turns them into sticky status flags and one interrupt line. Each event arrives as a single-cycle pulse. It sets its own flag, and the flag stays set until software reads the status word. A separate interrupt mask decides which flags may drive the interrupt output. Software changes the mask only through two write addresses. One address sets mask bits and the other clears them, so no read-modify-write is needed.

Software usually reads the status word once before it starts a command, which discards stale events. It then waits for the interrupt or for the command-done flag. That flag rises only when the instruction-end event and the chip-select-rise event have both been recorded since the last status read. Bit 24 of the status word is not sticky: it shows the controller-enabled level live.

The register port is a plain 32-bit read and write interface. Read data is combinational in the cycle of the read strobe. The asynchronous reset is released to the logic through a short synchroniser.

Top module: `sm_event_irq`

## Requirements
- R1: After reset, the mask reads zero, every sticky flag reads zero, `irq_o` is low and `cmd_done_o` is low.
- R2: An event pulse is captured at the next clock edge into its status bit, and the bit stays set until a status read. The positions follow `evt_i` index order: 0 to bit 0 (receive data ready), 1 to bit 1 (transmit holding empty), 2 to bit 2 (transmitter empty), 3 to bit 3 (overrun), 4 to bit 8 (chip-select rise), 5 to bit 9 (chip-select fall), 6 to bit 10 (instruction end).
- R3: A read at offset 0x10 returns the sticky flags with `ctrl_en_i` in bit 24. The sticky flags clear at the end of that read cycle. Bit 24 always follows `ctrl_en_i` and is never cleared.
- R4: An event pulse in the same cycle as a status read does not appear in that read's data. It is kept and appears in the next status read.
- R5: A write at offset 0x14 sets every mask bit written as 1. Bits written as 0 keep their value.
- R6: A write at offset 0x18 clears every mask bit written as 1. Bits written as 0 keep their value.
- R7: A read at offset 0x1C returns the mask. Only bits 0-3, 8-10 and 24 can be set, and all other bits read as 0.
- R8: `irq_o` is high exactly when the status word (sticky flags plus the live bit 24) ANDed with the mask is non-zero.
- R9: `cmd_done_o` is high exactly when both the chip-select-rise flag (bit 8) and the instruction-end flag (bit 10) are set.
- R10: Writes to offsets 0x10 and 0x1C change nothing. Reads of 0x14, 0x18, unmapped or misaligned offsets return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 7 | Single-cycle event pulses, index order as in R2 |
| ctrl_en_i | input | 1 | Live controller-enabled level, shown in status bit 24 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of `reg_rd_i` |
| irq_o | output | 1 | Interrupt line |
| cmd_done_o | output | 1 | Command fully completed |

## Verification
The bench builds the unit with `ADDR_W` = 6 and `RST_STAGES` = 3. The narrow address port lets it reach every word offset of the register window. It also reaches a misaligned offset and the top of the address space without any wide constants. The three-stage synchroniser makes the bench wait a reset-release window longer than the default, so a fixed two-cycle assumption in the reset path would show up as a wrong reset-state check.

// File: rtl/smirq_pkg.sv
package smirq_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_EVT = 7;

  // status word bit positions (decoded by software, so fixed)
  localparam int unsigned BIT_RXRDY   = 0;
  localparam int unsigned BIT_TXHOLD  = 1;
  localparam int unsigned BIT_TXIDLE  = 2;
  localparam int unsigned BIT_OVERRUN = 3;
  localparam int unsigned BIT_CSRISE  = 8;
  localparam int unsigned BIT_CSFALL  = 9;
  localparam int unsigned BIT_INSTEND = 10;
  localparam int unsigned BIT_CTRLON  = 24;

  // register byte offsets
  localparam int unsigned OFS_STAT = 'h10;
  localparam int unsigned OFS_SET  = 'h14;
  localparam int unsigned OFS_CLR  = 'h18;
  localparam int unsigned OFS_MASK = 'h1C;

  typedef struct packed {
    logic stat_rd;
    logic msk_set;
    logic msk_clr;
    logic msk_rd;
  } reg_access_t;

  // event input index -> status bit position
  function automatic int unsigned evt_bit(int unsigned idx);
    case (idx)
      0:       return BIT_RXRDY;
      1:       return BIT_TXHOLD;
      2:       return BIT_TXIDLE;
      3:       return BIT_OVERRUN;
      4:       return BIT_CSRISE;
      5:       return BIT_CSFALL;
      default: return BIT_INSTEND;
    endcase
  endfunction

  // every bit position that exists in the status/mask layout
  function automatic logic [WORD_W-1:0] impl_bits();
    logic [WORD_W-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < NUM_EVT; i++) r[evt_bit(i)] = 1'b1;
    r[BIT_CTRLON] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/smirq_rst_sync.sv
module smirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/smirq_decode.sv
module smirq_decode
  import smirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_access_t       acc_o
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  always_comb begin
    acc_o         = '0;
    acc_o.stat_rd = rd_i && (addr_i == A_STAT);
    acc_o.msk_rd  = rd_i && (addr_i == A_MASK);
    acc_o.msk_set = wr_i && (addr_i == A_SET);
    acc_o.msk_clr = wr_i && (addr_i == A_CLR);
  end

endmodule

// File: rtl/smirq_flags.sv
module smirq_flags
  import smirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  output logic [WORD_W-1:0]  sticky_o
);

  logic [NUM_EVT-1:0] flag_vec;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic bit_q;
    logic bit_d;
    logic bit_en;

    // a new event wins over the read clear, so nothing is lost
    assign bit_en = evt_i[i] | clr_i;
    assign bit_d  = evt_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign flag_vec[i] = bit_q;
  end

  always_comb begin
    sticky_o = '0;
    for (int unsigned i = 0; i < NUM_EVT; i++) sticky_o[evt_bit(i)] = flag_vec[i];
  end

endmodule

// File: rtl/smirq_mask.sv
module smirq_mask
  import smirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] mask_o
);

  localparam logic [WORD_W-1:0] KEEP = impl_bits();

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (KEEP[b]) begin : g_keep
      logic q;
      logic d;
      logic en;

      assign en = (set_i | clr_i) & wdata_i[b];
      assign d  = set_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end

      assign mask_o[b] = q;
    end else begin : g_none
      assign mask_o[b] = 1'b0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^(wdata_i & ~KEEP);

endmodule

// File: rtl/sm_event_irq.sv
module sm_event_irq
  import smirq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ctrl_en_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               cmd_done_o
);

  logic              rst_sync_n;
  reg_access_t       acc;
  logic [WORD_W-1:0] sticky_w;
  logic [WORD_W-1:0] mask_w;
  logic [WORD_W-1:0] live_w;
  logic [WORD_W-1:0] status_w;

  smirq_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  smirq_decode #(.ADDR_W(ADDR_W)) i_decode (
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .acc_o  (acc)
  );

  smirq_flags i_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (evt_i),
    .clr_i    (acc.stat_rd),
    .sticky_o (sticky_w)
  );

  smirq_mask i_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (acc.msk_set),
    .clr_i   (acc.msk_clr),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_w)
  );

  always_comb begin
    live_w             = '0;
    live_w[BIT_CTRLON] = ctrl_en_i;
  end

  assign status_w = sticky_w | live_w;

  always_comb begin
    reg_rdata_o = '0;
    if (acc.stat_rd)     reg_rdata_o = status_w;
    else if (acc.msk_rd) reg_rdata_o = mask_w;
  end

  assign irq_o      = |(status_w & mask_w);
  assign cmd_done_o = sticky_w[BIT_CSRISE] & sticky_w[BIT_INSTEND];

endmodule

// File: rtl/smirq_checker.sv
module smirq_checker
  import smirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               reg_wr_i,
  input logic               reg_rd_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [WORD_W-1:0]  reg_wdata_i,
  input logic [WORD_W-1:0]  sticky_q,
  input logic [WORD_W-1:0]  mask_q,
  input logic               irq_o,
  input logic               cmd_done_o
);

  localparam logic [WORD_W-1:0] KEEP = impl_bits();

  logic stat_rd, msk_set, msk_clr;
  assign stat_rd = reg_rd_i && (reg_addr_i == ADDR_W'(OFS_STAT));
  assign msk_set = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_SET));
  assign msk_clr = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CLR));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    p_evt_capture_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      evt_i[i] |=> sticky_q[evt_bit(i)]);
  end

  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !stat_rd |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_rd && (evt_i == '0)) |=> (sticky_q == '0));

  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    msk_set |=> ((mask_q & $past(reg_wdata_i & KEEP)) == $past(reg_wdata_i & KEEP)));

  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    msk_clr |=> ((mask_q & $past(reg_wdata_i)) == '0));

  p_mask_static_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !(msk_set || msk_clr) |=> $stable(mask_q));

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));

  p_done_by_event_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cmd_done_o) |-> ($past(evt_i[4]) || $past(evt_i[6])));

endmodule

bind sm_event_irq smirq_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .evt_i       (evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sticky_q    (sticky_w),
  .mask_q      (mask_w),
  .irq_o       (irq_o),
  .cmd_done_o  (cmd_done_o)
);

// File: tb/test_sm_event_irq.sv
module test_sm_event_irq;

  localparam int AW = 6;
  localparam int RS = 3;
  localparam int NE = 7;

  localparam logic [AW-1:0] A_STAT = 6'h10;
  localparam logic [AW-1:0] A_SET  = 6'h14;
  localparam logic [AW-1:0] A_CLR  = 6'h18;
  localparam logic [AW-1:0] A_MASK = 6'h1C;
  localparam logic [31:0]   IMPL   = 32'h0100_070F;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [NE-1:0] evt;
  logic          ctrl;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq, done;

  sm_event_irq #(.ADDR_W(AW), .RST_STAGES(RS)) i_sm_event_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .ctrl_en_i   (ctrl),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .cmd_done_o  (done)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_sticky;
  logic [31:0] m_mask;
  int pos_tab [NE] = '{0, 1, 2, 3, 8, 9, 10};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bits_of(input logic [NE-1:0] ev);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < NE; i++) r[pos_tab[i]] = ev[i];
    return r;
  endfunction

  function automatic logic [31:0] live();
    return {7'b0, ctrl, 24'b0};
  endfunction

  // monitor: pops the expected read word when the design answers
  always @(negedge clk) begin
    exp_t e;
    if (rd) begin
      if (sb.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata);
      end else begin
        e = sb.pop_front();
        check(e.tag, rdata, e.val);
      end
    end
  end

  task automatic rd_reg(input logic [AW-1:0] a, input logic [31:0] e, input string tag,
                        input logic [NE-1:0] ev);
    @(posedge clk); #1;
    rd = 1'b1; addr = a; evt = ev;
    sb.push_back('{e, tag});
    @(posedge clk); #1;
    rd = 1'b0; evt = '0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0; wdata = '0;
  endtask

  task automatic stat_read(input string tag, input logic [NE-1:0] ev);
    logic [31:0] e;
    e = m_sticky | live();
    rd_reg(A_STAT, e, tag, ev);
    m_sticky = bits_of(ev);
  endtask

  task automatic pulse(input logic [NE-1:0] ev);
    @(posedge clk); #1;
    evt = ev;
    @(posedge clk); #1;
    evt = '0;
    m_sticky = m_sticky | bits_of(ev);
  endtask

  task automatic lvl(input string tag);
    @(negedge clk);
    check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, |((m_sticky | live()) & m_mask)});
    check({tag, " R9 done"}, {31'b0, done}, {31'b0, m_sticky[8] & m_sticky[10]});
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; evt = '0; ctrl = 1'b0; wr = 1'b0; rd = 1'b0;
    addr = '0; wdata = '0; m_sticky = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    lvl("R1 during reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (RS + 1) @(posedge clk);
    #1;

    // R1 reset state
    lvl("R1 after reset");
    rd_reg(A_MASK, 32'h0, "R1 mask after reset", '0);
    stat_read("R1 status after reset", '0);

    // R3 live enable bit
    ctrl = 1'b1;
    stat_read("R3 live enable bit", '0);
    stat_read("R3 live bit not cleared by read", '0);

    // R2 each event position, R3 clear on read
    for (int i = 0; i < NE; i++) begin
      pulse(NE'(1) << i);
      stat_read($sformatf("R2 event %0d position", i), '0);
      stat_read($sformatf("R3 event %0d cleared", i), '0);
    end

    // R9 all events together, mask zero keeps irq low (R8)
    pulse(7'h7F);
    lvl("R9 all events");
    stat_read("R2 all events word", '0);
    lvl("R9 done cleared by read");

    // R9 order: one event is not enough
    pulse(7'b1000000);
    lvl("R9 instruction end alone");
    pulse(7'b0010000);
    lvl("R9 both seen");
    stat_read("R9 flush", '0);

    // R4 coincident event with status read
    pulse(7'b0000001);
    stat_read("R4 read with coincident event", 7'b0000100);
    stat_read("R4 coincident event kept", '0);

    // R5 R6 R7 mask handling
    wr_reg(A_SET, 32'hFFFF_FFFF); m_mask = IMPL;
    rd_reg(A_MASK, m_mask, "R7 unimplemented mask bits read zero", '0);
    wr_reg(A_CLR, 32'h0000_0005); m_mask = m_mask & ~32'h5;
    rd_reg(A_MASK, m_mask, "R6 clear selected bits", '0);
    wr_reg(A_SET, 32'h0);
    rd_reg(A_MASK, m_mask, "R5 zero write no change", '0);
    wr_reg(A_CLR, 32'h0);
    rd_reg(A_MASK, m_mask, "R6 zero write no change", '0);
    wr_reg(A_SET, 32'h0000_0001); m_mask = m_mask | 32'h1;
    rd_reg(A_MASK, m_mask, "R5 set single bit", '0);

    // R8 interrupt
    lvl("R8 live bit unmasked");
    wr_reg(A_CLR, 32'hFFFF_FFFF); m_mask = '0;
    wr_reg(A_SET, 32'h0000_0008); m_mask = 32'h8;
    lvl("R8 masked off");
    pulse(7'b0000001);
    lvl("R8 masked event no irq");
    pulse(7'b0001000);
    lvl("R8 overrun raises irq");
    stat_read("R8 flush", '0);
    lvl("R8 irq drops after read");

    // R10 ignored accesses
    pulse(7'b0100000);
    wr_reg(A_STAT, 32'hFFFF_FFFF);
    wr_reg(A_MASK, 32'hFFFF_FFFF);
    rd_reg(A_MASK, m_mask, "R10 mask unchanged by bad writes", '0);
    rd_reg(A_SET, 32'h0, "R10 enable offset reads zero", '0);
    rd_reg(A_CLR, 32'h0, "R10 disable offset reads zero", '0);
    rd_reg(6'h00, 32'h0, "R10 unmapped offset reads zero", '0);
    rd_reg(6'h3C, 32'h0, "R10 top offset reads zero", '0);
    rd_reg(6'h11, 32'h0, "R10 misaligned offset reads zero", '0);
    stat_read("R10 flag survived other accesses", '0);

    ctrl = 1'b0;
    stat_read("R3 live bit follows level", '0);

    @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    finish_run();
  end

endmodule